// File: doc/BRIEF.md
# Priority interrupt controller with vector latching

This block collects interrupt requests from a small set of sources and decides which one the processor should service next. Each source has a programmable 4-bit priority. The lowest-numbered sources carry flags that software raises and lowers through register writes. The remaining sources take their flags from peripheral pins. A source counts only while its flag is set, its enable pin is high and its mask pin is low. It must also outrank the current-priority level held inside the block.

When an eligible source exists, the block latches the winner's index and priority and raises a single request line. That latched vector stays fixed until the processor acknowledges it. There is no spurious-vector path: if the source drops away after the request is raised, the processor still receives that source's vector. On acknowledge, the current priority takes the winner's priority and the previous level is kept in a one-deep save slot. An end-of-interrupt pulse restores the saved level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `cur_pri` is 0, every source priority is 0 and every software flag is clear.
- R2: A source is eligible only when its flag is 1, its `src_enable` bit is 1, its `src_mask` bit is 0, and its priority is strictly greater than `cur_pri`. A priority of 0 is never eligible.
- R3: Among eligible sources, the one with the numerically highest priority wins. Equal priorities go to the lowest source index.
- R4: `irq_req` rises on the clock edge after an eligible winner first exists, and the winner's index is latched at that edge. The request and the latched vector then stay unchanged until acknowledge, even if the source drops or a higher-priority source appears.
- R5: An `irq_ack` pulse while `irq_req` is 1 loads `cur_pri` with the latched priority at the next edge and lowers `irq_req` at that edge. The previous `cur_pri` goes into a single save slot. `irq_ack` is ignored while `irq_req` is 0.
- R6: An `irq_eoi` pulse loads `cur_pri` from the save slot. If `irq_ack` fires in the same cycle, the acknowledge takes precedence and the end-of-interrupt pulse is dropped.
- R7: `vec_offset` equals 0x0800 + 4 × `vec_index`.
- R8: The register port behaves as follows. A write to address n (0 to 7) sets the priority of source n from `wr_data[3:0]`. Address 8 writes `cur_pri` from `wr_data[3:0]`. Address 9 sets each software flag n whose `wr_data` bit n is 1. Address 10 clears each software flag n whose `wr_data` bit n is 1. Sources 0 to 4 use the software flags. Source 5+k uses `hw_flag[k]`.
- R9: Raising `src_enable` or dropping `src_mask` while a source's flag is already set makes the source eligible, exactly as a fresh flag event would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_flag | input | 3 | Peripheral flags for sources 5 to 7 |
| src_enable | input | 8 | Per-source enable |
| src_mask | input | 8 | Per-source mask (1 blocks the source) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 5 | Register write data |
| irq_ack | input | 1 | Processor acknowledge pulse |
| irq_eoi | input | 1 | End-of-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_index | output | 3 | Latched winning source index |
| vec_offset | output | 16 | Vector table offset of the latched source |
| cur_pri | output | 4 | Current-priority level |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- A source whose priority equals `cur_pri` must stay silent. An off-by-one compare would raise a request there.
- Two sources tied at the same priority must resolve to the lower index. A reversed scan would deliver the higher index.
- A source is cleared, and then a higher one is raised, while a request is pending. A design with a spurious-vector path, or one that re-arbitrates the latch, would drop the request or change `vec_index`.
- An acknowledge and an end-of-interrupt arrive together, and enable and mask are toggled on a flag that is already set. A wrong precedence would show the restored level instead of the new one. A design that reacts only to flag edges would never raise the request.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Byte offset of a source's entry in the vector table.
  function automatic logic [15:0] vec_offset_of(input logic [15:0] base,
                                                input int unsigned step,
                                                input int unsigned idx);
    return base + 16'(step * idx);
  endfunction

  // Strict "outranks" relation used for both arbitration and the level check.
  function automatic logic pri_beats(input logic [7:0] cand,
                                     input logic [7:0] ref_pri);
    return cand > ref_pri;
  endfunction

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int NSRC = 8,
  parameter int NSW  = 5,
  parameter int PRIW = 4,
  localparam int NHW = NSRC - NSW
) (
  input  logic [NSW-1:0]       sw_flag,
  input  logic [NHW-1:0]       hw_flag,
  input  logic [NSRC-1:0]      src_enable,
  input  logic [NSRC-1:0]      src_mask,
  input  logic [NSRC*PRIW-1:0] pri_flat,
  output logic [NSRC-1:0]      active
);

  logic [NSRC-1:0] flag_eff;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < NSW) begin : g_sw
      assign flag_eff[i] = sw_flag[i];
    end else begin : g_hw
      assign flag_eff[i] = hw_flag[i-NSW];
    end
    // Level-based gating: enable/mask edges act exactly like flag edges.
    assign active[i] = flag_eff[i] && src_enable[i] && !src_mask[i]
                       && (pri_flat[i*PRIW +: PRIW] != '0);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int PRIW = 4,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]      active,
  input  logic [NSRC*PRIW-1:0] pri_flat,
  input  logic [PRIW-1:0]      cur_pri,
  output logic                 win_valid,
  output logic [IDXW-1:0]      win_idx,
  output logic [PRIW-1:0]      win_pri
);

  always_comb begin
    win_pri = '0;
    win_idx = '0;
    // Ascending scan with a strict compare keeps the lowest index on ties.
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && pri_beats(8'(pri_flat[i*PRIW +: PRIW]), 8'(win_pri))) begin
        win_pri = pri_flat[i*PRIW +: PRIW];
        win_idx = IDXW'(i);
      end
    end
    win_valid = pri_beats(8'(win_pri), 8'(cur_pri));
  end

endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold #(
  parameter int NSRC = 8,
  parameter int PRIW = 4,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_valid,
  input  logic [IDXW-1:0] win_idx,
  input  logic [PRIW-1:0] win_pri,
  input  logic            irq_ack,
  output logic            hold_valid,
  output logic [IDXW-1:0] hold_idx,
  output logic [PRIW-1:0] hold_pri,
  output logic            ack_fire,
  output logic            capture
);

  assign ack_fire = irq_ack && hold_valid;
  assign capture  = win_valid && !hold_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_idx   <= '0;
      hold_pri   <= '0;
    end else if (ack_fire) begin
      hold_valid <= 1'b0;
    end else if (capture) begin
      hold_valid <= 1'b1;
      hold_idx   <= win_idx;
      hold_pri   <= win_pri;
    end
  end

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid && !irq_ack |=> hold_valid); // R4
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid && !irq_ack |=> $stable(hold_idx) && $stable(hold_pri)); // R4
  AST_HELD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> hold_pri != '0); // R2
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !hold_valid); // R5

endmodule

// File: rtl/irq_pri_regs.sv
module irq_pri_regs #(
  parameter int NSRC = 8,
  parameter int NSW  = 5,
  parameter int PRIW = 4,
  parameter int AW   = 4,
  parameter int DW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 ack_fire,
  input  logic                 irq_eoi,
  input  logic [PRIW-1:0]      hold_pri,
  output logic [NSRC*PRIW-1:0] pri_flat,
  output logic [PRIW-1:0]      cur_pri,
  output logic [NSW-1:0]       sw_flag
);

  localparam logic [AW-1:0] A_CUR = AW'(NSRC);
  localparam logic [AW-1:0] A_SET = AW'(NSRC + 1);
  localparam logic [AW-1:0] A_CLR = AW'(NSRC + 2);

  logic [PRIW-1:0] save_q;
  logic            wr_cur, wr_set, wr_clr;

  assign wr_cur = wr_en && (wr_addr == A_CUR);
  assign wr_set = wr_en && (wr_addr == A_SET);
  assign wr_clr = wr_en && (wr_addr == A_CLR);

  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    logic [PRIW-1:0] pri_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  pri_q <= '0;
      else if (wr_en && (wr_addr == AW'(i)))       pri_q <= wr_data[PRIW-1:0];
    end
    assign pri_flat[i*PRIW +: PRIW] = pri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_flag <= '0;
    else if (wr_set)  sw_flag <= sw_flag | wr_data[NSW-1:0];
    else if (wr_clr)  sw_flag <= sw_flag & ~wr_data[NSW-1:0];
  end

  // Acknowledge outranks end-of-interrupt, which outranks a register write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pri <= '0;
      save_q  <= '0;
    end else if (ack_fire) begin
      save_q  <= cur_pri;
      cur_pri <= hold_pri;
    end else if (irq_eoi) begin
      cur_pri <= save_q;
    end else if (wr_cur) begin
      cur_pri <= wr_data[PRIW-1:0];
    end
  end

  AST_ACK_LOADS_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> cur_pri == $past(hold_pri)); // R5
  AST_EOI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eoi && !ack_fire |=> cur_pri == $past(save_q)); // R6
  AST_ACK_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> save_q == $past(cur_pri)); // R5

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int          NSRC     = 8,
  parameter int          NSW      = 5,
  parameter int          PRIW     = 4,
  parameter logic [15:0] VEC_BASE = 16'h0800,
  parameter int          VEC_STEP = 4,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int NHW  = NSRC - NSW,
  localparam int AW   = $clog2(NSRC + 3),
  localparam int DW   = (NSW > PRIW) ? NSW : PRIW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NHW-1:0]  hw_flag,
  input  logic [NSRC-1:0] src_enable,
  input  logic [NSRC-1:0] src_mask,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            irq_ack,
  input  logic            irq_eoi,
  output logic            irq_req,
  output logic [IDXW-1:0] vec_index,
  output logic [15:0]     vec_offset,
  output logic [PRIW-1:0] cur_pri
);

  logic [NSRC*PRIW-1:0] pri_flat;
  logic [NSW-1:0]       sw_flag;
  logic [NSRC-1:0]      active;
  logic                 win_valid;
  logic [IDXW-1:0]      win_idx;
  logic [PRIW-1:0]      win_pri;
  logic                 hold_valid;
  logic [IDXW-1:0]      hold_idx;
  logic [PRIW-1:0]      hold_pri;
  logic                 ack_fire;
  logic                 capture;

  irq_pri_regs #(.NSRC(NSRC), .NSW(NSW), .PRIW(PRIW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_fire(ack_fire), .irq_eoi(irq_eoi), .hold_pri(hold_pri),
    .pri_flat(pri_flat), .cur_pri(cur_pri), .sw_flag(sw_flag)
  );

  irq_src_gate #(.NSRC(NSRC), .NSW(NSW), .PRIW(PRIW)) u_gate (
    .sw_flag(sw_flag), .hw_flag(hw_flag), .src_enable(src_enable),
    .src_mask(src_mask), .pri_flat(pri_flat), .active(active)
  );

  irq_arbiter #(.NSRC(NSRC), .PRIW(PRIW)) u_arb (
    .active(active), .pri_flat(pri_flat), .cur_pri(cur_pri),
    .win_valid(win_valid), .win_idx(win_idx), .win_pri(win_pri)
  );

  irq_vec_hold #(.NSRC(NSRC), .PRIW(PRIW)) u_hold (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
    .win_pri(win_pri), .irq_ack(irq_ack), .hold_valid(hold_valid),
    .hold_idx(hold_idx), .hold_pri(hold_pri), .ack_fire(ack_fire),
    .capture(capture)
  );

  assign irq_req    = hold_valid;
  assign vec_index  = hold_idx;
  assign vec_offset = vec_offset_of(VEC_BASE, VEC_STEP, int'(hold_idx));

  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> active[win_idx]); // R3
  AST_CAPTURE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> irq_req && vec_index == $past(win_idx)); // R4
  AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && !win_valid |=> !irq_req); // R2

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hw_flag = '0;
  logic [7:0]  src_enable = '0;
  logic [7:0]  src_mask = 8'hFF;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [4:0]  wr_data = '0;
  logic        irq_ack = 1'b0;
  logic        irq_eoi = 1'b0;
  logic        irq_req;
  logic [2:0]  vec_index;
  logic [15:0] vec_offset;
  logic [3:0]  cur_pri;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_flag(hw_flag), .src_enable(src_enable),
    .src_mask(src_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .irq_eoi(irq_eoi), .irq_req(irq_req),
    .vec_index(vec_index), .vec_offset(vec_offset), .cur_pri(cur_pri)
  );

  // {pri[7..0] nibbles, sw set, hw, enable, mask, cur, exp_req, exp_idx}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {32'h0000_0000, 8'h1F, 8'h07, 8'hFF, 8'h00, 4'd0,  4'd0, 4'd0},  // R2 pri 0
    {32'h0000_0030, 8'h02, 8'h00, 8'hFF, 8'h00, 4'd0,  4'd1, 4'd1},  // R2
    {32'h0000_0030, 8'h02, 8'h00, 8'hFF, 8'h00, 4'd3,  4'd0, 4'd0},  // R2 equal
    {32'h0000_0030, 8'h02, 8'h00, 8'hFF, 8'h00, 4'd2,  4'd1, 4'd1},  // R2 above
    {32'h0500_0500, 8'h04, 8'h02, 8'hFF, 8'h00, 4'd0,  4'd1, 4'd2},  // R3 tie
    {32'h9000_0002, 8'h01, 8'h04, 8'hFF, 8'h00, 4'd0,  4'd1, 4'd7},  // R3 high
    {32'h9000_0002, 8'h01, 8'h04, 8'hFF, 8'h80, 4'd0,  4'd1, 4'd0},  // R2 mask
    {32'h9000_0002, 8'h01, 8'h04, 8'h7F, 8'h00, 4'd0,  4'd1, 4'd0},  // R2 enable
    {32'h9000_0002, 8'h01, 8'h00, 8'hFF, 8'h00, 4'd0,  4'd1, 4'd0},  // R8 hw flag
    {32'h000E_F000, 8'h18, 8'h00, 8'hFF, 8'h00, 4'd14, 4'd1, 4'd3},  // R3
    {32'h000E_F000, 8'h18, 8'h00, 8'hFF, 8'h00, 4'd15, 4'd0, 4'd0},  // R2 top
    {32'h0010_0000, 8'h00, 8'h01, 8'hFF, 8'h00, 4'd0,  4'd1, 4'd5}   // R8 hw map
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] en, input logic [7:0] msk,
                          input logic [2:0] hw);
    @(negedge clk);
    rst_n = 1'b0; irq_ack = 1'b0; irq_eoi = 1'b0; wr_en = 1'b0;
    src_enable = en; src_mask = msk; hw_flag = hw;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d[4:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic ack, input logic eoi);
    irq_ack = ack; irq_eoi = eoi;
    @(negedge clk);
    irq_ack = 1'b0; irq_eoi = 1'b0;
  endtask

  task automatic chk_vec(input string tag, input int idx);
    chk({tag, " req"}, int'(irq_req), 1);
    chk({tag, " idx"}, int'(vec_index), idx);
    chk("R7 offset", int'(vec_offset), 2048 + idx * 4);
  endtask

  initial begin
    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [75:0] e;
      e = VEC[v];
      do_reset(8'h00, 8'hFF, 3'b000);
      for (int s = 0; s < 8; s++) wr(4'(s), {4'h0, e[44 + s*4 +: 4]});
      wr(4'd9, e[43:36]);
      hw_flag = e[30:28];
      src_enable = e[27:20];
      wr(4'd8, {4'h0, e[11:8]});
      src_mask = e[19:12];
      cyc(2);
      chk($sformatf("R2/R3 vec%0d req", v), int'(irq_req), int'(e[7:4]));
      if (e[7:4] != 0) begin
        chk($sformatf("R3 vec%0d idx", v), int'(vec_index), int'(e[3:0]));
        chk("R7 offset", int'(vec_offset), 2048 + int'(e[3:0]) * 4);
      end
    end

    // R1: reset state
    do_reset(8'hFF, 8'h00, 3'b111);
    cyc(2);
    chk("R1 req after reset", int'(irq_req), 0);
    chk("R1 cur_pri after reset", int'(cur_pri), 0);
    wr(4'd0, 8'h01);
    cyc(2);
    chk("R1 sw flags clear", int'(irq_req), 0);

    // R4/R5/R6: latching, acknowledge, end-of-interrupt
    do_reset(8'hFF, 8'h00, 3'b000);
    wr(4'd1, 8'h03);
    wr(4'd9, 8'h02);
    cyc(2);
    chk_vec("R4 first", 1);
    wr(4'd10, 8'h02);
    cyc(2);
    chk_vec("R4 source dropped", 1);
    wr(4'd4, 8'h09);
    wr(4'd9, 8'h10);
    cyc(2);
    chk_vec("R4 locked vs higher", 1);
    pulse(1'b1, 1'b0);
    chk("R5 cur_pri after ack", int'(cur_pri), 3);
    chk("R5 req after ack", int'(irq_req), 0);
    cyc(1);
    chk_vec("R4 next winner", 4);
    pulse(1'b1, 1'b0);
    chk("R5 cur_pri second ack", int'(cur_pri), 9);
    pulse(1'b0, 1'b1);
    chk("R6 eoi restores", int'(cur_pri), 3);
    cyc(2);
    chk_vec("R6 re-request", 4);
    pulse(1'b1, 1'b1);
    chk("R6 ack over eoi", int'(cur_pri), 9);
    pulse(1'b1, 1'b0);
    chk("R5 ack ignored when idle", int'(cur_pri), 9);

    // R9/R8: enable and mask edges, software clear, level write
    do_reset(8'hFB, 8'h00, 3'b000);
    wr(4'd2, 8'h04);
    wr(4'd9, 8'h04);
    cyc(2);
    chk("R2 disabled source", int'(irq_req), 0);
    src_enable = 8'hFF;
    cyc(2);
    chk_vec("R9 enable rise", 2);
    pulse(1'b1, 1'b0);
    chk("R5 cur_pri", int'(cur_pri), 4);
    wr(4'd10, 8'h04);
    pulse(1'b0, 1'b1);
    cyc(2);
    chk("R6 cur_pri back", int'(cur_pri), 0);
    chk("R8 sw clear", int'(irq_req), 0);
    src_mask = 8'h04;
    wr(4'd9, 8'h04);
    cyc(2);
    chk("R2 masked source", int'(irq_req), 0);
    src_mask = 8'h00;
    cyc(2);
    chk_vec("R9 unmask", 2);
    pulse(1'b1, 1'b0);
    wr(4'd8, 8'h07);
    chk("R8 cur_pri write", int'(cur_pri), 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule